// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Usage Tracking

This block caches page mappings for a processor: it turns a 20-bit virtual page number into a 20-bit physical page number. A lookup presents the page number, a 12-bit in-page offset and the access kind (read or write). Every stored entry is compared against the page number at once. One cycle later the block reports one of three outcomes: a hit with the full 32-bit physical address, a miss, or a protection fault. A protection fault means the page is present but its rights forbid the access.

Each entry carries a valid flag, a referenced flag, a modified (dirty) flag and a two-bit rights field. The hardware keeps the referenced and modified flags current. A permitted access marks its entry as referenced, and a permitted write also marks it as modified. A miss does not stall the block. The external page-table logic resolves the miss and then installs the mapping through the fill port.

On a fill, a free entry is used first. When every entry is valid, a circular pointer picks the victim. It passes over referenced entries, clearing each flag as it goes, and stops at the first unreferenced entry. Whenever a fill displaces a valid mapping, the block reports that mapping's page number and modified flag, so the caller can see which pages need writing back.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every entry is invalid, all response and eviction outputs are low, and a first lookup reports a miss.
- R2: A lookup presented in one cycle is answered on the next clock edge: resp_valid is high, and exactly one of resp_hit, resp_miss and resp_prot is high. With no lookup presented, all four outputs are low.
- R3: On a hit, resp_paddr holds the stored physical page number in bits 31:12 and the unchanged lookup offset in bits 11:0.
- R4: The rights field uses two bits. Bit 0 permits reads and bit 1 permits writes, so 00 = none, 01 = read only, 10 = write only, 11 = read/write. A matching access whose bit is clear raises resp_prot instead of resp_hit, and it changes neither the referenced nor the modified flag.
- R5: A write hit sets the entry's modified flag. A read hit leaves it unchanged.
- R6: A fill uses an invalid entry whenever one exists, choosing the lowest index first, and reports no eviction.
- R7: When all entries are valid, the victim is chosen by the circular pointer. The pointer starts at index 0 after reset or invalidate. Starting there, it clears the referenced flag of each referenced entry it passes and stops at the first unreferenced one. If every entry is referenced, all flags end up cleared and the entry at the pointer is chosen. After such a fill, the pointer moves to the entry after the victim.
- R8: A newly filled entry starts referenced and unmodified.
- R9: Filling a page number that is already present replaces that entry in place, so at most one entry ever matches a page number.
- R10: inval_all clears every valid flag and resets the pointer in one cycle. A lookup in the next cycle misses.
- R11: The cycle after a fill that replaces a valid entry, evict_valid is high for one cycle, with evict_vpn and evict_dirty showing the displaced page number and its modified flag.
- R12: A permitted access (hit) sets its entry's referenced flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Invalidate every entry |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_write | input | 1 | 1 = write access, 0 = read access |
| lookup_vpn | input | 20 | Virtual page number to translate |
| lookup_offset | input | 12 | In-page offset, passed through |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Page number of the new mapping |
| fill_ppn | input | 20 | Physical page number of the new mapping |
| fill_rights | input | 2 | Rights of the new mapping (bit 0 read, bit 1 write) |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Permitted match |
| resp_miss | output | 1 | No valid entry matched |
| resp_prot | output | 1 | Match, but access not permitted |
| resp_paddr | output | 32 | Physical address on a hit, else zero |
| evict_valid | output | 1 | A fill displaced a valid mapping |
| evict_vpn | output | 20 | Displaced page number |
| evict_dirty | output | 1 | Displaced mapping was modified |

## Verification
The bench fills all 64 entries and then drives the replacement pointer through three cases: a full sweep where every entry is referenced, a referenced entry that must be skipped, and a wrap-around past freshly filled entries. An off-by-one pointer, a sweep that does not clear the flags it passes, or a fill that leaves new entries unreferenced would each evict the wrong page number. Re-filling a page that is already present must both report its old modified flag and stop a second entry from matching. A design that appends a duplicate would return the stale physical page or lose the dirty state. Writes against read-only pages must fault without marking the page modified, which a later eviction report exposes. Lookups after invalidate must miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef logic [1:0] rights_t;

  localparam int RIGHT_RD_BIT = 0;
  localparam int RIGHT_WR_BIT = 1;

  // Access permitted by a rights field for a given access kind.
  function automatic logic rights_permit(rights_t r, logic is_write);
    return is_write ? r[RIGHT_WR_BIT] : r[RIGHT_RD_BIT];
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 64,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [TAG_W-1:0] key,
  input  logic [N-1:0]     valid,
  input  logic [TAG_W-1:0] tags [N],
  output logic [N-1:0]     match,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     ref_bits,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] victim_idx,
  output logic             use_sweep,
  output logic [N-1:0]     clr_mask
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] sweep_idx;

  // Lowest-index invalid entry.
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // Circular sweep from the pointer: referenced entries are passed and
  // cleared; the first unreferenced one is taken. All referenced -> ptr.
  always_comb begin
    logic found;
    found     = 1'b0;
    sweep_idx = ptr;
    clr_mask  = '0;
    for (int k = 0; k < N; k++) begin
      int p;
      p = (int'(ptr) + k) % N;
      if (!found) begin
        if (ref_bits[p]) begin
          clr_mask[p] = 1'b1;
        end else begin
          found     = 1'b1;
          sweep_idx = IDX_W'(p);
        end
      end
    end
  end

  assign use_sweep  = !free_any;
  assign victim_idx = free_any ? free_idx : sweep_idx;
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inval_all,
  input  logic             lookup_valid,
  input  logic             lookup_write,
  input  logic [VPN_W-1:0] lookup_vpn,
  input  logic [OFF_W-1:0] lookup_offset,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_rights,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_miss,
  output logic             resp_prot,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             evict_valid,
  output logic [VPN_W-1:0] evict_vpn,
  output logic             evict_dirty
);
  import tlb_pkg::*;

  // Entry storage: payload arrays carry no reset; flags are vectors.
  logic [VPN_W-1:0]   tag_q    [ENTRIES];
  logic [PPN_W-1:0]   ppn_q    [ENTRIES];
  rights_t            rights_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, ref_q, dirty_q;
  logic [IDX_W-1:0]   ptr_q;

  logic [ENTRIES-1:0] valid_d, ref_d, dirty_d;
  logic [IDX_W-1:0]   ptr_d;

  logic [ENTRIES-1:0] look_match, fill_match;
  logic               look_any, fill_any;
  logic [IDX_W-1:0]   look_idx, fill_idx;

  logic [IDX_W-1:0]   vict_idx;
  logic               vict_sweep;
  logic [ENTRIES-1:0] vict_clr;

  logic [IDX_W-1:0]   tgt_idx;
  logic               sweep_used;
  logic               acc_ok, look_hit, fill_go;

  tlb_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_look (
    .key(lookup_vpn), .valid(valid_q), .tags(tag_q),
    .match(look_match), .any(look_any), .idx(look_idx)
  );

  tlb_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_fill (
    .key(fill_vpn), .valid(valid_q), .tags(tag_q),
    .match(fill_match), .any(fill_any), .idx(fill_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_vict (
    .valid(valid_q), .ref_bits(ref_q), .ptr(ptr_q),
    .victim_idx(vict_idx), .use_sweep(vict_sweep), .clr_mask(vict_clr)
  );

  assign acc_ok     = rights_permit(rights_q[look_idx], lookup_write);
  assign look_hit   = lookup_valid && look_any && acc_ok;
  assign fill_go    = fill_valid && !inval_all;
  assign tgt_idx    = fill_any ? fill_idx : vict_idx;
  assign sweep_used = !fill_any && vict_sweep;

  always_comb begin
    valid_d = valid_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    ptr_d   = ptr_q;
    if (look_hit) begin
      ref_d[look_idx] = 1'b1;
      if (lookup_write) dirty_d[look_idx] = 1'b1;
    end
    if (fill_valid) begin
      if (sweep_used) begin
        ref_d = ref_d & ~vict_clr;
        ptr_d = (vict_idx == IDX_W'(ENTRIES - 1)) ? '0 : vict_idx + 1'b1;
      end
      valid_d[tgt_idx] = 1'b1;
      ref_d[tgt_idx]   = 1'b1;
      dirty_d[tgt_idx] = 1'b0;
    end
    if (inval_all) begin
      valid_d = '0;
      ref_d   = '0;
      dirty_d = '0;
      ptr_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[tgt_idx]    <= fill_vpn;
      ppn_q[tgt_idx]    <= fill_ppn;
      rights_q[tgt_idx] <= fill_rights;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_miss   <= 1'b0;
      resp_prot   <= 1'b0;
      resp_paddr  <= '0;
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_dirty <= 1'b0;
    end else begin
      resp_valid  <= lookup_valid;
      resp_hit    <= look_hit;
      resp_miss   <= lookup_valid && !look_any;
      resp_prot   <= lookup_valid && look_any && !acc_ok;
      resp_paddr  <= look_hit ? {ppn_q[look_idx], lookup_offset} : '0;
      evict_valid <= fill_go && valid_q[tgt_idx];
      evict_vpn   <= fill_go ? tag_q[tgt_idx] : '0;
      evict_dirty <= fill_go && valid_q[tgt_idx] && dirty_q[tgt_idx];
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int ENTRIES = 64,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               inval_all,
  input logic               lookup_valid,
  input logic [OFF_W-1:0]   lookup_offset,
  input logic               fill_valid,
  input logic               resp_valid,
  input logic               resp_hit,
  input logic               resp_miss,
  input logic               resp_prot,
  input logic [PA_W-1:0]    resp_paddr,
  input logic               evict_valid,
  input logic [ENTRIES-1:0] look_match,
  input logic [ENTRIES-1:0] fill_match
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!resp_valid && !evict_valid));

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($countones({resp_hit, resp_miss, resp_prot}) == 1));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> (!resp_hit && !resp_miss && !resp_prot));

  a_r2_answer_next: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> resp_valid);

  a_r3_offset_pass: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid ##1 resp_hit) |-> (resp_paddr[OFF_W-1:0] == $past(lookup_offset)));

  a_r9_unique_lookup: assert property (@(posedge clk) disable iff (rst)
    $countones(look_match) <= 1);

  a_r9_unique_fill: assert property (@(posedge clk) disable iff (rst)
    $countones(fill_match) <= 1);

  a_r10_inval_misses: assert property (@(posedge clk) disable iff (rst)
    (inval_all ##1 (lookup_valid && !inval_all)) |=> resp_miss);

  a_r11_evict_after_fill: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> $past(fill_valid));
endmodule

bind tlb_xlat tlb_checker #(.ENTRIES(ENTRIES), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tlb_xlat_bench.sv
module tlb_xlat_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inval_all = 1'b0;
  logic        lookup_valid = 1'b0, lookup_write = 1'b0;
  logic [19:0] lookup_vpn = '0;
  logic [11:0] lookup_offset = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [1:0]  fill_rights = '0;
  logic        resp_valid, resp_hit, resp_miss, resp_prot;
  logic [31:0] resp_paddr;
  logic        evict_valid, evict_dirty;
  logic [19:0] evict_vpn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [1:0] RT_NONE = 2'b00, RT_RO = 2'b01, RT_WO = 2'b10, RT_RW = 2'b11;
  localparam logic [19:0] BASE = 20'h10000;

  always #10 clk = ~clk;

  tlb_xlat u_tlb_xlat (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Lookup: drive at negedge, result registered at posedge, sample at next negedge.
  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off, input logic wr);
    @(negedge clk);
    lookup_valid = 1'b1; lookup_vpn = vpn; lookup_offset = off; lookup_write = wr;
    @(negedge clk);
    lookup_valid = 1'b0; lookup_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] rt);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rights = rt;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_hit(string req, logic [19:0] ppn, logic [11:0] off);
    chk(req, "valid", resp_valid, 1);
    chk(req, "hit", resp_hit, 1);
    chk(req, "miss", resp_miss, 0);
    chk(req, "prot", resp_prot, 0);
    chk(req, "paddr", resp_paddr, {ppn, off});
  endtask

  task automatic t_reset();
    chk("R1", "resp_valid", resp_valid, 0);
    chk("R1", "evict_valid", evict_valid, 0);
    chk("R1", "hit", resp_hit, 0);
    lookup(20'h00abc, 12'h123, 1'b0);
    chk("R1", "miss", resp_miss, 1);
    chk("R2", "outcome valid", resp_valid, 1);
    chk("R2", "no hit on miss", resp_hit, 0);
    @(negedge clk);
    chk("R2", "idle valid", resp_valid, 0);
    chk("R2", "idle miss", resp_miss, 0);
  endtask

  task automatic t_basic();
    fill(20'h0000a, 20'h7a5c3, RT_RW);
    chk("R6", "no evict on free fill", evict_valid, 0);
    lookup(20'h0000a, 12'hfed, 1'b0);
    expect_hit("R3", 20'h7a5c3, 12'hfed);
    lookup(20'h0000a, 12'h001, 1'b1);
    expect_hit("R3", 20'h7a5c3, 12'h001);
  endtask

  task automatic t_rights();
    fill(20'h0000b, 20'h22222, RT_RO);
    fill(20'h0000c, 20'h33333, RT_NONE);
    fill(20'h0000d, 20'h44444, RT_WO);
    lookup(20'h0000b, 12'h010, 1'b1);
    chk("R4", "ro write prot", resp_prot, 1);
    chk("R4", "ro write no hit", resp_hit, 0);
    chk("R4", "ro write paddr", resp_paddr, 0);
    lookup(20'h0000b, 12'h010, 1'b0);
    expect_hit("R4", 20'h22222, 12'h010);
    lookup(20'h0000c, 12'h0, 1'b0);
    chk("R4", "none read prot", resp_prot, 1);
    lookup(20'h0000d, 12'h0, 1'b0);
    chk("R4", "wo read prot", resp_prot, 1);
    lookup(20'h0000d, 12'h044, 1'b1);
    expect_hit("R4", 20'h44444, 12'h044);
  endtask

  task automatic t_dirty();
    // Entry 0x0000a was written in t_basic: replace in place.
    fill(20'h0000a, 20'h55555, RT_RW);
    chk("R9", "replace evict", evict_valid, 1);
    chk("R11", "evict vpn", evict_vpn, 20'h0000a);
    chk("R5", "write hit dirty", evict_dirty, 1);
    lookup(20'h0000a, 12'h777, 1'b0);
    expect_hit("R9", 20'h55555, 12'h777);
    fill(20'h0000a, 20'h66666, RT_RW);
    chk("R8", "new entry clean", evict_dirty, 0);
    // 0x0000b: one read hit and one faulting write only.
    fill(20'h0000b, 20'h22223, RT_RO);
    chk("R5", "read hit clean", evict_dirty, 0);
    chk("R4", "fault leaves clean", evict_valid, 1);
    @(negedge clk);
    chk("R11", "evict one cycle", evict_valid, 0);
  endtask

  task automatic t_inval();
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    lookup(20'h0000a, 12'h0, 1'b0);
    chk("R10", "miss after inval", resp_miss, 1);
    lookup(20'h0000d, 12'h0, 1'b1);
    chk("R10", "miss after inval 2", resp_miss, 1);
  endtask

  task automatic t_clock();
    int bad;
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      fill(BASE + 20'(i), 20'h80000 + 20'(i), RT_RW);
      if (evict_valid) bad++;
    end
    chk("R6", "free fills no evict", bad, 0);
    lookup(BASE + 20'd63, 12'h0, 1'b0);
    expect_hit("R6", 20'h80000 + 20'd63, 12'h0);
    // All referenced: sweep clears all, takes entry 0.
    fill(20'h20000, 20'h90000, RT_RW);
    chk("R7", "full sweep evict", evict_valid, 1);
    chk("R7", "full sweep vpn", evict_vpn, BASE);
    lookup(BASE + 20'd2, 12'h0, 1'b0);
    chk("R12", "hit entry 2", resp_hit, 1);
    fill(20'h20001, 20'h90001, RT_RW);
    chk("R7", "next unreferenced", evict_vpn, BASE + 20'd1);
    fill(20'h20002, 20'h90002, RT_RW);
    chk("R12", "referenced skipped", evict_vpn, BASE + 20'd3);
    bad = 0;
    for (int i = 4; i < 64; i++) begin
      fill(20'h30000 + 20'(i), 20'h0, RT_RW);
      if (!evict_valid || evict_vpn != BASE + 20'(i)) bad++;
    end
    chk("R7", "sequential sweep", bad, 0);
    // Wrap: entries 0,1 hold new fills (referenced), entry 2 was cleared.
    fill(20'h20003, 20'h90003, RT_RW);
    chk("R8", "new entries referenced", evict_vpn, BASE + 20'd2);
    lookup(20'h20000, 12'h0ab, 1'b0);
    expect_hit("R7", 20'h90000, 12'h0ab);
    lookup(BASE + 20'd2, 12'h0, 1'b0);
    chk("R7", "victim gone", resp_miss, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rights();
    t_dirty();
    t_inval();
    t_clock();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule